// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block takes a parallel-RGB-to-DSI bridge from reset to running video without any software stepping through the sequence. After a `start` pulse it first checks that the requested colour depth is one the bridge can carry. It then pulses the bridge reset pin and, when a read-back path exists, confirms the bridge identity. Next it loads the video timing registers, puts the link in low-power command mode, programs and enables the PLL, and sends the exit-sleep and display-on panel commands. As the last step it switches the data lanes to high-speed with video enabled.

Every register access goes out through a simple request port to an external serial register master. Each request is held stable until the master pulses `req_done`. All waits are counted in ticks of an external one-microsecond strobe. The PLL word and the low-power divider are computed elsewhere and arrive as inputs. `done` or `error` reports the outcome and stays valid until the next start.

Top module: `dsi_bringup_seq`

## Requirements
- R1: After reset `busy`, `done`, `error` and `req_valid` are 0, and `bridge_rst_n` is 1.
- R2: A start with `color_bpp` other than 16, 18 or 24 raises `error` on the next cycle. No request is issued and `bridge_rst_n` never goes low.
- R3: After a valid start, `bridge_rst_n` is held low for RESET_US microsecond ticks, then released. A further RESET_US ticks pass before the first request.
- R4: With `readback_en`=1, register 0xB0 is read and must return 0x2828, then 0xB7 is read and must return 0x0301. A mismatch ends the run with `error`=1 and no further request. With `readback_en`=0 no read is issued.
- R5: The timing writes go in this order, each with the named value in the upper byte first: 0xB1={vsync,hsync}, 0xB2={vsync+vback,hsync+hback} (each sum modulo 256), 0xB3={vfront,hfront}, 0xB4=active width, 0xB5=active height.
- R6: 0xB6 gets 0x08 OR a format code: 0 for 16 bpp, 1 for packed 18 bpp, 2 for loose 18 bpp (`loose18`=1), 3 for 24 bpp. Then 0xDE gets `lane_count`-1.
- R7: 0xB7 is then written with 0x0342 (low-power data lanes, high-speed clock lane, command-set packets, plus the reset-default bits 8 and 9). Bit 5 (0x0020) is added when `pclk_ref`=1.
- R8: Next come 0xBA=`pll_word`, 0xB8=0, 0xBB=`lp_div` and 0xB9=1. After that, LOCK_US ticks pass before the next request.
- R9: Each panel command is a write of 1 to 0xBC followed by the command byte to 0xBF. 0x11 is sent first, then a wait of `sleep_ms`×US_PER_MS ticks. 0x29 is sent second, then a wait of `on_ms`×US_PER_MS ticks.
- R10: The last write sets 0xB7 to the R7 value OR 0x0009 (high-speed data lanes, video enable). `done` then rises and `busy` falls.
- R11: `done` and `error` hold their value until the next `start`, which clears them.
- R12: While `req_valid` is high and `req_done` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the sequence (accepted when not busy) |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| readback_en | input | 1 | Read path to the bridge exists; do identity checks |
| pclk_ref | input | 1 | Pixel clock is the PLL reference |
| vsync_len | input | 8 | Vertical sync width |
| hsync_len | input | 8 | Horizontal sync width |
| vback | input | 8 | Vertical back porch |
| hback | input | 8 | Horizontal back porch |
| vfront | input | 8 | Vertical front porch |
| hfront | input | 8 | Horizontal front porch |
| h_active | input | 16 | Active width |
| v_active | input | 16 | Active height |
| color_bpp | input | 6 | Colour depth in bits per pixel |
| loose18 | input | 1 | Loose packing for 18 bpp |
| lane_count | input | 4 | Number of data lanes |
| pll_word | input | 16 | Precomputed PLL configuration word |
| lp_div | input | 16 | Precomputed low-power clock divider field |
| sleep_ms | input | 16 | Delay after exit-sleep in ms |
| on_ms | input | 16 | Delay after display-on in ms |
| bridge_rst_n | output | 1 | Bridge reset pin, active low |
| req_valid | output | 1 | Register access request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Bridge register number |
| req_wdata | output | 16 | Write value |
| req_done | input | 1 | Master finished the current request |
| req_rdata | input | 16 | Read value, valid with req_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| error | output | 1 | Sequence failed |

## Verification
The hardest conditions to reach are the two identity mismatches. A wrong value from the first read must stop the run after exactly one request. A wrong value from the second read must stop it after two. The bench gets there by having its behavioural register master return a programmable identity word and configuration word, which forces each failure in turn. The second hard area is the three waits. Each is measured in microsecond ticks between the end of one request and the rise of the next, while the tick strobe runs at a fixed spacing that does not line up with the requests.

// File: rtl/bseq_pkg.sv
// Shared types and register constants for the bring-up sequencer.
// Assumes 8-bit register numbers and 16-bit register values.
package bseq_pkg;
    typedef enum logic [2:0] {
        K_WRITE,
        K_READ,
        K_SKIP,
        K_DELAY,
        K_END
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [31:0] dly;
    } step_t;

    localparam int          IDX_W        = 5;
    localparam logic [15:0] ID_WORD      = 16'h2828;
    localparam logic [15:0] CFG_DEFAULT  = 16'h0301;
    localparam logic [15:0] CFG_LP_MODE  = 16'h0342;
    localparam logic [15:0] CFG_PCLK_SEL = 16'h0020;
    localparam logic [15:0] CFG_HS_VIDEO = 16'h0009;

    localparam logic [7:0] A_ID      = 8'hB0;
    localparam logic [7:0] A_SYNC    = 8'hB1;
    localparam logic [7:0] A_BACK    = 8'hB2;
    localparam logic [7:0] A_FRONT   = 8'hB3;
    localparam logic [7:0] A_HACT    = 8'hB4;
    localparam logic [7:0] A_VACT    = 8'hB5;
    localparam logic [7:0] A_VMODE   = 8'hB6;
    localparam logic [7:0] A_CFG     = 8'hB7;
    localparam logic [7:0] A_VCHAN   = 8'hB8;
    localparam logic [7:0] A_PLLEN   = 8'hB9;
    localparam logic [7:0] A_PLLW    = 8'hBA;
    localparam logic [7:0] A_LPDIV   = 8'hBB;
    localparam logic [7:0] A_PKTLEN  = 8'hBC;
    localparam logic [7:0] A_PKTDATA = 8'hBF;
    localparam logic [7:0] A_LANES   = 8'hDE;

    localparam logic [15:0] CMD_WAKE = 16'h0011;
    localparam logic [15:0] CMD_ON   = 16'h0029;
endpackage

// File: rtl/bseq_timer.sv
// Microsecond down-counter used for every wait in the sequencer.
// Assumes tick is a one-cycle strobe; a load takes priority over a tick.
module bseq_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load a new wait or count one tick down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (tick && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/bseq_steps.sv
// Combinational list of sequencer steps, indexed by step number.
// Assumes color depth has already been checked by the caller.
module bseq_steps
    import bseq_pkg::*;
#(
    parameter int LOCK_US   = 500,
    parameter int US_PER_MS = 1000
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             readback_en,
    input  logic             pclk_ref,
    input  logic [7:0]       vsync_len,
    input  logic [7:0]       hsync_len,
    input  logic [7:0]       vback,
    input  logic [7:0]       hback,
    input  logic [7:0]       vfront,
    input  logic [7:0]       hfront,
    input  logic [15:0]      h_active,
    input  logic [15:0]      v_active,
    input  logic [5:0]       color_bpp,
    input  logic             loose18,
    input  logic [3:0]       lane_count,
    input  logic [15:0]      pll_word,
    input  logic [15:0]      lp_div,
    input  logic [15:0]      sleep_ms,
    input  logic [15:0]      on_ms,
    output step_t            step
);
    logic [7:0]  vsum, hsum;
    logic [1:0]  fmt;
    logic [15:0] cfg_lp;
    logic [3:0]  lanes_m1;

    // Derived field values shared by several steps.
    always_comb begin
        vsum     = vsync_len + vback;
        hsum     = hsync_len + hback;
        lanes_m1 = lane_count - 4'd1;
        cfg_lp   = CFG_LP_MODE | (pclk_ref ? CFG_PCLK_SEL : 16'h0000);
        if (color_bpp == 6'd16)      fmt = 2'd0;
        else if (color_bpp == 6'd18) fmt = loose18 ? 2'd2 : 2'd1;
        else                         fmt = 2'd3;
    end

    // Map the step number to its access or wait.
    always_comb begin
        step.kind = K_WRITE;
        step.addr = 8'h00;
        step.data = 16'h0000;
        step.dly  = 32'd0;
        case (idx)
            5'd0:  begin step.kind = readback_en ? K_READ : K_SKIP;
                         step.addr = A_ID;  step.data = ID_WORD; end
            5'd1:  begin step.kind = readback_en ? K_READ : K_SKIP;
                         step.addr = A_CFG; step.data = CFG_DEFAULT; end
            5'd2:  begin step.addr = A_SYNC;  step.data = {vsync_len, hsync_len}; end
            5'd3:  begin step.addr = A_BACK;  step.data = {vsum, hsum}; end
            5'd4:  begin step.addr = A_FRONT; step.data = {vfront, hfront}; end
            5'd5:  begin step.addr = A_HACT;  step.data = h_active; end
            5'd6:  begin step.addr = A_VACT;  step.data = v_active; end
            5'd7:  begin step.addr = A_VMODE; step.data = {12'h000, 2'b10, fmt}; end
            5'd8:  begin step.addr = A_LANES; step.data = {12'h000, lanes_m1}; end
            5'd9:  begin step.addr = A_CFG;   step.data = cfg_lp; end
            5'd10: begin step.addr = A_PLLW;  step.data = pll_word; end
            5'd11: begin step.addr = A_VCHAN; step.data = 16'h0000; end
            5'd12: begin step.addr = A_LPDIV; step.data = lp_div; end
            5'd13: begin step.addr = A_PLLEN; step.data = 16'h0001; end
            5'd14: begin step.kind = K_DELAY; step.dly = 32'(LOCK_US); end
            5'd15: begin step.addr = A_PKTLEN;  step.data = 16'h0001; end
            5'd16: begin step.addr = A_PKTDATA; step.data = CMD_WAKE; end
            5'd17: begin step.kind = K_DELAY;
                         step.dly = 32'(sleep_ms) * 32'(US_PER_MS); end
            5'd18: begin step.addr = A_PKTLEN;  step.data = 16'h0001; end
            5'd19: begin step.addr = A_PKTDATA; step.data = CMD_ON; end
            5'd20: begin step.kind = K_DELAY;
                         step.dly = 32'(on_ms) * 32'(US_PER_MS); end
            5'd21: begin step.addr = A_CFG; step.data = cfg_lp | CFG_HS_VIDEO; end
            default: step.kind = K_END;
        endcase
    end
endmodule

// File: rtl/dsi_bringup_seq.sv
// Bring-up sequencer for a parallel-RGB-to-DSI bridge: reset pulse,
// identity check, timing load, PLL start, two panel commands, video on.
// Assumes an external serial master that ends each request with req_done
// and a one-cycle us_tick strobe.
module dsi_bringup_seq
    import bseq_pkg::*;
#(
    parameter int RESET_US  = 10000,
    parameter int LOCK_US   = 500,
    parameter int US_PER_MS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        us_tick,
    input  logic        readback_en,
    input  logic        pclk_ref,
    input  logic [7:0]  vsync_len,
    input  logic [7:0]  hsync_len,
    input  logic [7:0]  vback,
    input  logic [7:0]  hback,
    input  logic [7:0]  vfront,
    input  logic [7:0]  hfront,
    input  logic [15:0] h_active,
    input  logic [15:0] v_active,
    input  logic [5:0]  color_bpp,
    input  logic        loose18,
    input  logic [3:0]  lane_count,
    input  logic [15:0] pll_word,
    input  logic [15:0] lp_div,
    input  logic [15:0] sleep_ms,
    input  logic [15:0] on_ms,
    output logic        bridge_rst_n,
    output logic        req_valid,
    output logic        req_write,
    output logic [7:0]  req_addr,
    output logic [15:0] req_wdata,
    input  logic        req_done,
    input  logic [15:0] req_rdata,
    output logic        busy,
    output logic        done,
    output logic        error
);
    typedef enum logic [2:0] {
        S_IDLE, S_RST_LO, S_RST_HI, S_STEP, S_REQ, S_DELAY, S_DONE, S_FAIL
    } state_e;

    state_e           state;
    logic [IDX_W-1:0] idx;
    logic [15:0]      expect_q;
    step_t            cur;
    logic             depth_ok, can_start, tmr_load, tmr_expired;
    logic [31:0]      tmr_val;

    bseq_steps #(.LOCK_US(LOCK_US), .US_PER_MS(US_PER_MS)) u_steps (
        .idx(idx), .readback_en(readback_en), .pclk_ref(pclk_ref),
        .vsync_len(vsync_len), .hsync_len(hsync_len), .vback(vback),
        .hback(hback), .vfront(vfront), .hfront(hfront),
        .h_active(h_active), .v_active(v_active), .color_bpp(color_bpp),
        .loose18(loose18), .lane_count(lane_count), .pll_word(pll_word),
        .lp_div(lp_div), .sleep_ms(sleep_ms), .on_ms(on_ms), .step(cur)
    );

    bseq_timer #(.W(32)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .tick(us_tick), .expired(tmr_expired)
    );

    // Start acceptance and timer load decisions.
    always_comb begin
        depth_ok  = (color_bpp == 6'd16) || (color_bpp == 6'd18) || (color_bpp == 6'd24);
        can_start = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
        tmr_load  = (can_start && start && depth_ok)
                  || (state == S_RST_LO && tmr_expired)
                  || (state == S_STEP && cur.kind == K_DELAY);
        tmr_val   = (state == S_STEP) ? cur.dly : 32'(RESET_US);
    end

    // Main sequencing state machine and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            idx          <= '0;
            bridge_rst_n <= 1'b1;
            req_valid    <= 1'b0;
            req_write    <= 1'b0;
            req_addr     <= 8'h00;
            req_wdata    <= 16'h0000;
            expect_q     <= 16'h0000;
        end else begin
            case (state)
                S_IDLE, S_DONE, S_FAIL: if (start) begin
                    if (!depth_ok) state <= S_FAIL;
                    else begin
                        state        <= S_RST_LO;
                        bridge_rst_n <= 1'b0;
                        idx          <= '0;
                    end
                end
                S_RST_LO: if (tmr_expired) begin
                    bridge_rst_n <= 1'b1;
                    state        <= S_RST_HI;
                end
                S_RST_HI: if (tmr_expired) state <= S_STEP;
                S_STEP: case (cur.kind)
                    K_WRITE, K_READ: begin
                        req_valid <= 1'b1;
                        req_write <= (cur.kind == K_WRITE);
                        req_addr  <= cur.addr;
                        req_wdata <= (cur.kind == K_WRITE) ? cur.data : 16'h0000;
                        expect_q  <= cur.data;
                        state     <= S_REQ;
                    end
                    K_DELAY: state <= S_DELAY;
                    K_SKIP:  idx   <= idx + 1'b1;
                    default: state <= S_DONE;
                endcase
                S_REQ: if (req_done) begin
                    req_valid <= 1'b0;
                    if (!req_write && req_rdata != expect_q) state <= S_FAIL;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= S_STEP;
                    end
                end
                S_DELAY: if (tmr_expired) begin
                    idx   <= idx + 1'b1;
                    state <= S_STEP;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy  = !can_start;
    assign done  = (state == S_DONE);
    assign error = (state == S_FAIL);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_done) |=> (req_valid && $stable(req_addr)
                                      && $stable(req_wdata) && $stable(req_write)));
    p_no_req_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_rst_n |-> !req_valid);
    p_bad_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !depth_ok) |=> (error && bridge_rst_n && !req_valid));
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    p_error_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);
    p_outcome_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy, done, error}) <= 1);
endmodule

// File: tb/dsi_bringup_seq_bench.sv
module dsi_bringup_seq_bench;
    localparam int RST_US = 6;
    localparam int LCK_US = 4;
    localparam int MS_US  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, us_tick = 1'b0, readback_en = 1'b1, pclk_ref = 1'b0;
    logic [7:0] vsync_len = 8'd3, hsync_len = 8'd8, vback = 8'd5, hback = 8'd12;
    logic [7:0] vfront = 8'd2, hfront = 8'd6;
    logic [15:0] h_active = 16'd800, v_active = 16'd480;
    logic [5:0] color_bpp = 6'd24;
    logic loose18 = 1'b0;
    logic [3:0] lane_count = 4'd4;
    logic [15:0] pll_word = 16'h40C8, lp_div = 16'h0003, sleep_ms = 16'd3, on_ms = 16'd2;
    logic bridge_rst_n, req_valid, req_write, busy, done, error;
    logic [7:0] req_addr;
    logic [15:0] req_wdata;
    logic req_done = 1'b0;
    logic [15:0] req_rdata = 16'h0000;

    int checks = 0, fails = 0;
    logic [15:0] id_model = 16'h2828, cfg_model = 16'h0301;
    logic [8:0]  log_ent [0:63];
    logic [15:0] log_dat [0:63];
    int nlog = 0;
    int lat = 2, tdiv = 0;
    int rst_lo_ticks = 0, meas_cnt = 0, meas_tag = 0;
    int meas_res [0:3];
    logic meas_on = 1'b0, rst_prev = 1'b1, rv_prev = 1'b0, rst_seen_low = 1'b0;
    logic [8:0]  exp_ent [0:63];
    logic [15:0] exp_dat [0:63];
    int nexp = 0;

    dsi_bringup_seq #(.RESET_US(RST_US), .LOCK_US(LCK_US), .US_PER_MS(MS_US)) u_dsi_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
        .readback_en(readback_en), .pclk_ref(pclk_ref), .vsync_len(vsync_len),
        .hsync_len(hsync_len), .vback(vback), .hback(hback), .vfront(vfront),
        .hfront(hfront), .h_active(h_active), .v_active(v_active),
        .color_bpp(color_bpp), .loose18(loose18), .lane_count(lane_count),
        .pll_word(pll_word), .lp_div(lp_div), .sleep_ms(sleep_ms), .on_ms(on_ms),
        .bridge_rst_n(bridge_rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .req_rdata(req_rdata), .busy(busy), .done(done), .error(error)
    );

    always #2.5 clk = ~clk;

    // Microsecond strobe every third cycle, and the register master model.
    always @(negedge clk) begin
        tdiv    <= (tdiv == 2) ? 0 : tdiv + 1;
        us_tick <= (tdiv == 2);
        req_done <= 1'b0;
        if (req_valid && !req_done) begin
            if (lat == 0) begin
                req_done <= 1'b1;
                lat <= 2;
                log_ent[nlog] <= {req_write, req_addr};
                log_dat[nlog] <= req_wdata;
                nlog <= nlog + 1;
                req_rdata <= (req_addr == 8'hB0) ? id_model :
                             (req_addr == 8'hB7) ? cfg_model : 16'h0000;
            end else lat <= lat - 1;
        end
    end

    // Tick windows: reset low, after reset release, lock, and both command waits.
    always @(posedge clk) begin
        rst_prev <= bridge_rst_n;
        rv_prev  <= req_valid;
        if (!bridge_rst_n) begin
            rst_seen_low <= 1'b1;
            if (us_tick) rst_lo_ticks <= rst_lo_ticks + 1;
        end
        if (!rst_prev && bridge_rst_n) begin
            meas_on <= 1'b1; meas_tag <= 0; meas_cnt <= us_tick ? 1 : 0;
        end else if (req_valid && req_done && req_write &&
                     (req_addr == 8'hB9 || (req_addr == 8'hBF && req_wdata != 16'h0001))) begin
            meas_on  <= 1'b1;
            meas_tag <= (req_addr == 8'hB9) ? 1 : (req_wdata == 16'h0011) ? 2 : 3;
            meas_cnt <= us_tick ? 1 : 0;
        end else if (meas_on) begin
            if (req_valid && !rv_prev) begin
                meas_on <= 1'b0;
                meas_res[meas_tag] <= meas_cnt;
            end else if (us_tick) meas_cnt <= meas_cnt + 1;
        end
    end

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic push(input logic wr, input logic [7:0] a, input logic [15:0] d);
        exp_ent[nexp] = {wr, a};
        exp_dat[nexp] = d;
        nexp++;
    endtask

    // Build the full expected request list from the requirements.
    task automatic build_expect(input logic [15:0] vmode);
        logic [15:0] cfg1;
        cfg1 = 16'h0342 | (pclk_ref ? 16'h0020 : 16'h0000);
        nexp = 0;
        if (readback_en) begin push(1'b0, 8'hB0, 16'h0); push(1'b0, 8'hB7, 16'h0); end
        push(1'b1, 8'hB1, {vsync_len, hsync_len});
        push(1'b1, 8'hB2, {8'(vsync_len + vback), 8'(hsync_len + hback)});
        push(1'b1, 8'hB3, {vfront, hfront});
        push(1'b1, 8'hB4, h_active);
        push(1'b1, 8'hB5, v_active);
        push(1'b1, 8'hB6, vmode);
        push(1'b1, 8'hDE, 16'(lane_count - 4'd1));
        push(1'b1, 8'hB7, cfg1);
        push(1'b1, 8'hBA, pll_word);
        push(1'b1, 8'hB8, 16'h0000);
        push(1'b1, 8'hBB, lp_div);
        push(1'b1, 8'hB9, 16'h0001);
        push(1'b1, 8'hBC, 16'h0001);
        push(1'b1, 8'hBF, 16'h0011);
        push(1'b1, 8'hBC, 16'h0001);
        push(1'b1, 8'hBF, 16'h0029);
        push(1'b1, 8'hB7, cfg1 | 16'h0009);
    endtask

    task automatic launch();
        @(negedge clk);
        nlog = 0; rst_lo_ticks = 0; rst_seen_low = 1'b0;
        for (int i = 0; i < 4; i++) meas_res[i] = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic compare_log(input string req);
        chk_eq({req, " count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            chk_eq({req, " entry"}, {7'd0, log_ent[i]}, {7'd0, exp_ent[i]});
            chk_eq({req, " data"}, {16'd0, log_dat[i]}, {16'd0, exp_dat[i]});
        end
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 done", done, 0);
        chk_eq("R1 error", error, 0);
        chk_eq("R1 req_valid", req_valid, 0);
        chk_eq("R1 bridge_rst_n", bridge_rst_n, 1);
    endtask

    // R3 R4 R5 R6 R7 R8 R9 R10: full run, read-back on, 24 bpp, own reference.
    task automatic t_full_24();
        readback_en = 1; pclk_ref = 0; color_bpp = 24; id_model = 16'h2828; cfg_model = 16'h0301;
        build_expect(16'h000B);
        launch();
        compare_log("R4 R5 R6 R7 R8 R9 R10 full run 24bpp");
        chk_rng("R3 reset low ticks", rst_lo_ticks, RST_US, RST_US + 1);
        chk_rng("R3 post-release ticks", meas_res[0], RST_US, RST_US + 1);
        chk_rng("R8 lock wait ticks", meas_res[1], LCK_US, LCK_US + 1);
        chk_rng("R9 sleep-exit wait ticks", meas_res[2], 3 * MS_US, 3 * MS_US + 1);
        chk_rng("R9 display-on wait ticks", meas_res[3], 2 * MS_US, 2 * MS_US + 1);
        chk_eq("R10 done", done, 1);
        chk_eq("R10 error", error, 0);
    endtask

    // R11: done holds while idle, and a new start clears it.
    task automatic t_hold();
        repeat (20) @(negedge clk);
        chk_eq("R11 done held", done, 1);
        chk_eq("R11 error held low", error, 0);
        start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
        chk_eq("R11 done cleared by start", done, 0);
        chk_eq("R11 busy after start", busy, 1);
        while (busy) @(negedge clk);
    endtask

    // R4 R5 R6 R7: no read-back, loose 18 bpp, pixel-clock reference, porch sums wrap.
    task automatic t_loose18();
        readback_en = 0; pclk_ref = 1; color_bpp = 18; loose18 = 1;
        vsync_len = 8'hF0; vback = 8'h20; lane_count = 4'd2;
        build_expect(16'h000A);
        launch();
        compare_log("R4 R5 R6 R7 loose18 no readback");
        chk_eq("R10 done loose18", done, 1);
    endtask

    // R6: packed 18 bpp and 16 bpp format codes.
    task automatic t_formats();
        loose18 = 0; color_bpp = 18; lane_count = 4'd1;
        build_expect(16'h0009);
        launch();
        compare_log("R6 packed18");
        color_bpp = 16;
        build_expect(16'h0008);
        launch();
        compare_log("R6 16bpp");
    endtask

    // R4: identity mismatch and configuration mismatch.
    task automatic t_bad_id();
        readback_en = 1; color_bpp = 24; id_model = 16'h1234;
        launch();
        chk_eq("R4 id mismatch error", error, 1);
        chk_eq("R4 id mismatch done", done, 0);
        chk_eq("R4 id mismatch request count", nlog, 1);
        id_model = 16'h2828; cfg_model = 16'h0300;
        launch();
        chk_eq("R4 cfg mismatch error", error, 1);
        chk_eq("R4 cfg mismatch request count", nlog, 2);
        cfg_model = 16'h0301;
    endtask

    // R2: unsupported depth fails at once with no bridge activity.
    task automatic t_bad_depth();
        color_bpp = 6'd20;
        launch();
        chk_eq("R2 error", error, 1);
        chk_eq("R2 no requests", nlog, 0);
        chk_eq("R2 reset pin untouched", rst_seen_low, 0);
        chk_eq("R2 bridge_rst_n high", bridge_rst_n, 1);
        color_bpp = 6'd24;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_24();
        t_hold();
        t_loose18();
        t_formats();
        t_bad_id();
        t_bad_depth();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule